// File: doc/BRIEF.md
# Radix-4 Circuit-Switched Exchange Node

This block is one switching element of a multistage interconnect. It has four input links and four output links and behaves as a full 4x4 crossbar. Packets travel over each link as a stream of 8-bit chunks, one per clock, flagged by a valid bit and a last-chunk bit. The first chunk of every packet is the destination label.

The node takes the output port from the two lowest bits of the label. It then passes the label on rotated right by two bits, so that the next stage finds its own two routing bits in the lowest position. A granted input keeps its output until the last chunk of the packet has gone through. A header aimed at a busy output is refused, and so is a header that loses the arbitration for a free output. The node does not buffer a refused packet. It pulses a reject line back toward the sender and discards the rest of that packet.

The node also honours a reject that arrives from the next stage on an output it holds. It frees that output, passes the reject back to the owning input and discards the remainder of the packet. In this way a blocked partial path is torn down toward its source, one stage at a time.

Top module: `xnode_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output valid bit and every input reject bit is 0.
- R2: A header (a valid chunk on an input with no open path) whose label bits [1:0] equal k, and which is granted, appears on output k one cycle later with valid set. Its data is the label rotated right by two bits ({d[1:0], d[7:2]}) and it keeps its last bit.
- R3: Once a path is open, each later valid chunk on that input appears unchanged on the same output one cycle later, with its last bit. A cycle in which the input's valid bit is low gives a cycle with the output's valid bit low.
- R4: A header aimed at an output held by another packet is not forwarded, and the reject line of its input is high in the next cycle. This includes an output whose last chunk arrives in the same cycle as the header.
- R5: When several inputs present headers for the same free output in one cycle, the lowest-numbered input wins and every other contender is rejected in the next cycle.
- R6: An output becomes free for a new header in the cycle after the last chunk of its packet has arrived.
- R7: After a reject, the input's remaining chunks up to and including its last chunk are discarded and appear on no output. The next chunk after that is treated as a header.
- R8: A reject driven back on an output while a path holds it frees the output, discards the chunk arriving in that cycle and the rest of the packet, and raises the owning input's reject line in the next cycle.
- R9: A reject driven back on an output that no path holds has no effect.
- R10: Paths from different inputs to different outputs run at the same time, each with one cycle of latency.
- R11: A header whose last bit is set is forwarded but does not hold its output. A header for that output in the next cycle is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 4 | Per-input chunk valid |
| in_last | input | 4 | Per-input last-chunk flag |
| in_data | input | 32 | Per-input chunk, input i in bits [8i+7:8i] |
| in_rej | output | 4 | Per-input reject toward the sender |
| out_vld | output | 4 | Per-output chunk valid |
| out_last | output | 4 | Per-output last-chunk flag |
| out_data | output | 32 | Per-output chunk, output o in bits [8o+7:8o] |
| out_rej | input | 4 | Per-output reject from the next stage |

## Verification
The hardest cases to reach are the ones where several things happen on one clock edge. One is a last chunk freeing an output in the same cycle that a new header asks for it. Another is a downstream reject landing in the middle of a held packet, while other inputs keep sending into the dropped stream. The stimulus builds these edges on purpose: it lines up a last chunk with a competing header, it keeps chunks flowing on a rejected input, and it pulses a backward reject in the middle of a packet, then sends a fresh header to the freed output. A behavioural reference model follows each of these cycle by cycle.

// File: rtl/xnode_pkg.sv
package xnode_pkg;
    localparam int PORTS  = 4;
    localparam int DATA_W = 8;
    localparam int SEL_W  = $clog2(PORTS);

    typedef logic [DATA_W-1:0] chunk_t;

    typedef enum logic [1:0] {
        IN_IDLE = 2'd0,
        IN_LINK = 2'd1,
        IN_DROP = 2'd2
    } in_state_e;

    typedef struct packed {
        logic   vld;
        logic   last;
        chunk_t data;
    } flit_t;

    // expose the next stage's routing bits
    function automatic chunk_t next_label(input chunk_t d);
        return {d[SEL_W-1:0], d[DATA_W-1:SEL_W]};
    endfunction
endpackage

// File: rtl/xnode_ingress.sv
module xnode_ingress
    import xnode_pkg::*;
#(
    parameter int NP = PORTS,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld_i,
    input  logic          last_i,
    input  logic [SW-1:0] hdr_bits_i,
    input  logic          grant_i,
    input  logic          deny_i,
    input  logic [NP-1:0] out_rej_i,
    output logic          hdr_req_o,
    output logic [SW-1:0] hdr_port_o,
    output logic          rej_o
);
    in_state_e     st;
    logic [SW-1:0] own;
    logic          kill;

    assign hdr_req_o  = vld_i && (st == IN_IDLE);
    assign hdr_port_o = hdr_bits_i;
    assign kill       = (st == IN_LINK) && out_rej_i[own];

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= IN_IDLE;
            own   <= '0;
            rej_o <= 1'b0;
        end else begin
            rej_o <= deny_i | kill;
            unique case (st)
                IN_IDLE: begin
                    if (grant_i && !last_i) begin
                        st  <= IN_LINK;
                        own <= hdr_bits_i;
                    end else if (deny_i && !last_i) begin
                        st <= IN_DROP;
                    end
                end
                IN_LINK: begin
                    if (kill)
                        st <= (vld_i && last_i) ? IN_IDLE : IN_DROP;
                    else if (vld_i && last_i)
                        st <= IN_IDLE;
                end
                IN_DROP: begin
                    if (vld_i && last_i)
                        st <= IN_IDLE;
                end
                default: st <= IN_IDLE;
            endcase
        end
    end

    // R4
    deny_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
        deny_i |-> (st == IN_IDLE));

    // R7
    drop_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (st == IN_DROP) && !(vld_i && last_i) |=> (st == IN_DROP));
endmodule

// File: rtl/xnode_arbiter.sv
module xnode_arbiter
    import xnode_pkg::*;
#(
    parameter int NP = PORTS,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] req_i,
    input  logic [NP-1:0] req_last_i,
    input  logic          rel_i,
    output logic [NP-1:0] grant_o,
    output logic [NP-1:0] deny_o,
    output logic          owned_o,
    output logic [SW-1:0] owner_o
);
    logic [SW-1:0] win;
    logic          found;

    always_comb begin
        grant_o = '0;
        win     = '0;
        found   = 1'b0;
        if (!owned_o) begin
            for (int i = 0; i < NP; i++) begin
                if (req_i[i] && !found) begin
                    found      = 1'b1;
                    win        = SW'(i);
                    grant_o[i] = 1'b1;
                end
            end
        end
        deny_o = req_i & ~grant_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owned_o <= 1'b0;
            owner_o <= '0;
        end else if (owned_o) begin
            if (rel_i)
                owned_o <= 1'b0;
        end else if (found && !req_last_i[win]) begin
            owned_o <= 1'b1;
            owner_o <= win;
        end
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        owned_o && rel_i |=> !owned_o);
endmodule

// File: rtl/xnode_top.sv
module xnode_top
    import xnode_pkg::*;
#(
    parameter int NP = PORTS,
    parameter int DW = DATA_W,
    parameter int SW = SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP-1:0]    in_vld,
    input  logic [NP-1:0]    in_last,
    input  logic [NP*DW-1:0] in_data,
    output logic [NP-1:0]    in_rej,
    output logic [NP-1:0]    out_vld,
    output logic [NP-1:0]    out_last,
    output logic [NP*DW-1:0] out_data,
    input  logic [NP-1:0]    out_rej
);
    logic [NP-1:0] hdr_req;
    logic [SW-1:0] hdr_port [NP];
    logic [NP-1:0] grant_in, deny_in;
    logic [NP-1:0] req_m   [NP];
    logic [NP-1:0] grant_m [NP];
    logic [NP-1:0] deny_m  [NP];
    logic [NP-1:0] owned;
    logic [SW-1:0] owner   [NP];
    logic [NP-1:0] rel;
    flit_t         nxt     [NP];
    flit_t         cur     [NP];

    // fold per-output grant/deny back onto the inputs
    always_comb begin
        grant_in = '0;
        deny_in  = '0;
        for (int o = 0; o < NP; o++) begin
            grant_in |= grant_m[o];
            deny_in  |= deny_m[o];
        end
    end

    for (genvar i = 0; i < NP; i++) begin : g_in
        xnode_ingress #(.NP(NP), .SW(SW)) u_ing (
            .clk        (clk),
            .rst        (rst),
            .vld_i      (in_vld[i]),
            .last_i     (in_last[i]),
            .hdr_bits_i (in_data[i*DW +: SW]),
            .grant_i    (grant_in[i]),
            .deny_i     (deny_in[i]),
            .out_rej_i  (out_rej),
            .hdr_req_o  (hdr_req[i]),
            .hdr_port_o (hdr_port[i]),
            .rej_o      (in_rej[i])
        );
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        always_comb begin
            for (int i = 0; i < NP; i++)
                req_m[o][i] = hdr_req[i] && (hdr_port[i] == SW'(o));
        end

        assign rel[o] = owned[o] &&
                        (out_rej[o] || (in_vld[owner[o]] && in_last[owner[o]]));

        xnode_arbiter #(.NP(NP), .SW(SW)) u_arb (
            .clk        (clk),
            .rst        (rst),
            .req_i      (req_m[o]),
            .req_last_i (in_last),
            .rel_i      (rel[o]),
            .grant_o    (grant_m[o]),
            .deny_o     (deny_m[o]),
            .owned_o    (owned[o]),
            .owner_o    (owner[o])
        );

        always_comb begin
            nxt[o] = '0;
            for (int i = 0; i < NP; i++) begin
                if (grant_m[o][i])
                    nxt[o] = '{vld: 1'b1, last: in_last[i],
                               data: next_label(in_data[i*DW +: DW])};
            end
            if (owned[o] && !out_rej[o] && in_vld[owner[o]])
                nxt[o] = '{vld: 1'b1, last: in_last[owner[o]],
                           data: in_data[owner[o]*DW +: DW]};
        end

        always_ff @(posedge clk) begin
            if (rst) cur[o] <= '0;
            else     cur[o] <= nxt[o];
        end

        assign out_vld[o]            = cur[o].vld;
        assign out_last[o]           = cur[o].last;
        assign out_data[o*DW +: DW]  = cur[o].data;

        // R3
        fwd_source_chk: assert property (@(posedge clk) disable iff (rst)
            out_vld[o] |-> $past(in_vld != '0));
    end
endmodule

// File: tb/sim_xnode_top.sv
module sim_xnode_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  in_vld, in_last, out_rej, in_rej, out_vld, out_last;
    logic [31:0] in_data, out_data;

    always #5 clk = ~clk;

    xnode_top u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_last(in_last),
        .in_data(in_data), .in_rej(in_rej), .out_vld(out_vld),
        .out_last(out_last), .out_data(out_data), .out_rej(out_rej)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference: 0 idle, 1 linked, 2 dropping
    int       st [4];
    int       own [4];
    int       owner [4];
    int       st0 [4];
    bit       busy [4];
    bit       claimed [4];
    bit       ev [4];
    bit       el [4];
    bit [7:0] ed [4];
    bit       er [4];
    int       mo, mp;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) begin
                st[k] = 0; own[k] = 0; owner[k] = -1;
                ev[k] = 0; el[k] = 0; ed[k] = 0; er[k] = 0;
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                busy[k] = (owner[k] >= 0); claimed[k] = 0;
                ev[k] = 0; el[k] = 0; ed[k] = 0; er[k] = 0; st0[k] = st[k];
            end
            for (int i = 0; i < 4; i++) begin
                if (st0[i] == 1) begin
                    mo = own[i];
                    if (out_rej[mo]) begin
                        er[i] = 1; owner[mo] = -1;
                        st[i] = (in_vld[i] && in_last[i]) ? 0 : 2;
                    end else if (in_vld[i]) begin
                        ev[mo] = 1; el[mo] = in_last[i]; ed[mo] = in_data[i*8 +: 8];
                        if (in_last[i]) begin st[i] = 0; owner[mo] = -1; end
                    end
                end else if (st0[i] == 2) begin
                    if (in_vld[i] && in_last[i]) st[i] = 0;
                end else if (in_vld[i]) begin
                    mp = int'(in_data[i*8 +: 2]);
                    if (busy[mp] || claimed[mp]) begin
                        er[i] = 1;
                        st[i] = in_last[i] ? 0 : 2;
                    end else begin
                        claimed[mp] = 1; ev[mp] = 1; el[mp] = in_last[i];
                        ed[mp] = {in_data[i*8 +: 2], in_data[i*8+2 +: 6]};
                        if (!in_last[i]) begin st[i] = 1; own[i] = mp; owner[mp] = i; end
                    end
                end
            end
        end
    end

    task automatic check(input string req);
        for (int o = 0; o < 4; o++) begin
            n_cmp++;
            if (out_vld[o] !== ev[o] ||
                (ev[o] && (out_last[o] !== el[o] || out_data[o*8 +: 8] !== ed[o]))) begin
                n_bad++;
                $display("FAIL %s out%0d: got v=%b l=%b d=%h exp v=%b l=%b d=%h", req, o,
                         out_vld[o], out_last[o], out_data[o*8 +: 8], ev[o], el[o], ed[o]);
            end
        end
        n_cmp++;
        if (in_rej !== {er[3], er[2], er[1], er[0]}) begin
            n_bad++;
            $display("FAIL %s in_rej: got %b exp %b", req, in_rej, {er[3], er[2], er[1], er[0]});
        end
    endtask

    task automatic tick(input string req);
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    task automatic clr();
        in_vld = '0; in_last = '0; in_data = '0; out_rej = '0;
    endtask

    task automatic put(input int i, input bit l, input bit [7:0] d);
        in_vld[i] = 1'b1; in_last[i] = l; in_data[i*8 +: 8] = d;
    endtask

    bit done = 0;

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        clr();
        rst = 1'b1;
        repeat (3) tick("R1");
        rst = 1'b0;
        tick("R1");

        // R2 header routing, R3 body with a gap
        put(0, 0, 8'h4E); tick("R2");
        put(0, 0, 8'hA1); tick("R3");
        clr(); tick("R3");
        put(0, 0, 8'h33); tick("R3");
        put(0, 1, 8'h5C); tick("R3");
        // R6 freed output taken on the very next cycle
        clr(); put(1, 0, 8'h12); tick("R6");
        put(1, 1, 8'h77); tick("R6");
        clr(); tick("R6");

        // R4 busy output, then R7 discard
        put(0, 0, 8'h01); tick("R4");
        put(0, 0, 8'h10); put(2, 0, 8'h05); tick("R4");
        put(0, 1, 8'h20); put(2, 0, 8'hFF); put(1, 1, 8'h09); tick("R4");
        clr(); put(2, 1, 8'hEE); tick("R7");
        clr(); put(2, 1, 8'h0D); tick("R7");
        clr(); tick("R7");

        // R5 three contenders on output 3
        put(1, 0, 8'h03); put(2, 0, 8'h07); put(3, 0, 8'h0B); tick("R5");
        put(1, 1, 8'h44); put(2, 1, 8'h55); put(3, 1, 8'h66); tick("R5");
        clr(); tick("R5");

        // R10 four parallel paths
        put(0, 0, 8'hC0); put(1, 0, 8'hC5); put(2, 0, 8'hCA); put(3, 0, 8'hCF); tick("R10");
        put(0, 0, 8'h01); put(1, 0, 8'h02); put(2, 0, 8'h03); put(3, 0, 8'h04); tick("R10");
        put(0, 1, 8'h91); put(1, 1, 8'h92); put(2, 1, 8'h93); put(3, 1, 8'h94); tick("R10");
        clr(); tick("R10");

        // R8 downstream reject mid-packet
        put(3, 0, 8'h80); tick("R8");
        put(3, 0, 8'h11); tick("R8");
        put(3, 0, 8'h22); out_rej[0] = 1'b1; tick("R8");
        out_rej[0] = 1'b0; put(3, 0, 8'h33); tick("R8");
        put(3, 1, 8'h44); tick("R8");
        clr(); put(2, 1, 8'h90); tick("R8");
        clr(); tick("R8");

        // R9 reject on an idle output
        out_rej = 4'b0100; put(0, 1, 8'h66); tick("R9");
        clr(); tick("R9");

        // R11 single-chunk packet leaves the output free
        put(0, 1, 8'h27); tick("R11");
        clr(); put(1, 0, 8'h3B); tick("R11");
        put(1, 1, 8'hAB); tick("R11");
        clr(); tick("R11");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule